// File: doc/BRIEF.md
# Two-Channel Bit-Interleaving Multiplexer with Deskew

This block turns one synchronous 128 kbit/s serial stream into two 64 kbit/s channels, A and B, by alternating bits between them. In the other direction it merges the two received channels back into a single 128 kbit/s stream. Both rates come from one clock. The full-rate clock runs the logic. A strobe output marks every second cycle, and that strobe is the 64 kbit/s timing for both channels.

The two channels can reach the receiver with different transit times. A delay line can be placed on either receive channel to cancel that difference. The delay is counted in channel-rate periods and runs from 0 to 31. It can be loaded from configuration pins at reset, or found by an auto-calibration search. The search runs while both channels carry a 9-stage pseudo-random test sequence. After calibration the block keeps checking the merged stream and flags any slip in the alignment.

The interface is plain serial bit-per-cycle. There is no valid/ready handshake and no back-pressure, because the line rate is fixed and every bit slot is used.

Top module: `bitpair_mux`

## Requirements
- R1: `stb64_o` is high on every second clock cycle after reset. The transmit bit presented in a cycle with the strobe low goes to channel A. The bit in the next cycle, with the strobe high, goes to channel B. Both channel outputs update together on the clock edge that ends the strobe-high cycle, and hold their values at every other edge.
- R2: The receive bits on `rx_a_i` and `rx_b_i` are sampled at the edge that ends a strobe-high cycle. After the deskew stage, the A bit appears on `out_bit_o` in the next cycle (strobe low) and the B bit in the cycle after that (strobe high).
- R3: A delay value D from 0 to 31 makes the delayed channel use the bit sampled D strobe periods earlier. The other channel is not delayed. With D = 0 both channels pass with no added delay.
- R4: The channel-select value 1 puts the delay on channel A, and 0 puts it on channel B.
- R5: The delay and channel-select pins are captured only while `rst_n` is low. Changing them while out of reset has no effect on the data path or on `cur_dly_o`. `cur_dly_o` always shows the delay in use.
- R6: When `auto_i` goes high, the search tries delays in the order 0, 1, 2 and so on. For each candidate it lets 16 merged bits go by and then checks the next 64 bits against the rule b[n] = b[n-5] xor b[n-9]. It stops at the first candidate with no mismatch and then holds that delay. `err_o` is high for the whole search.
- R7: After lock, `err_o` is updated at the end of each 80-bit window. It goes high if any merged bit in that window broke the rule, and low if the window was clean.
- R8: While `auto_i` is low, `err_o` stays low. A delay found by the search stays in use until the next reset.
- R9: During reset and right after it, both channel outputs, `out_bit_o` and `err_o` are 0, and `cur_dly_o` equals the configured delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate (128 kbit/s) clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| tx_bit_i | input | 1 | Full-rate transmit data, one bit per cycle |
| stb64_o | output | 1 | Channel-rate strobe, high on every second cycle |
| ch_a_o | output | 1 | Channel A transmit bit |
| ch_b_o | output | 1 | Channel B transmit bit |
| rx_a_i | input | 1 | Channel A receive bit, sampled at the end of a strobe-high cycle |
| rx_b_i | input | 1 | Channel B receive bit, sampled at the end of a strobe-high cycle |
| out_bit_o | output | 1 | Merged full-rate receive data |
| dly_cfg_i | input | 5 | Configured deskew delay, in channel periods |
| dly_sel_a_i | input | 1 | 1 delays channel A, 0 delays channel B |
| auto_i | input | 1 | High runs the auto-calibration search and then slip monitoring |
| cur_dly_o | output | 5 | Delay currently in use |
| err_o | output | 1 | Search in progress, or a slip was seen after lock |

## Verification
The transmit split is driven with random bits, which shows whether the channel order is right and whether the outputs hold between strobes. The receive merge is driven with random streams in which one channel lags by 0, 7 or 31 periods, on each channel in turn. An exact match shows the tap, the choice of channel and the A-before-B order, while a wrong tap by even one period shows up as mismatched bits. A test-sequence stream with a known lag of 5 or 12 tests the search. Reaching exactly that delay shows that the search starts at 0 and stops at the first clean candidate. Changing the lag by one period after lock, and then setting it back, shows that the slip flag is raised and later cleared.

// File: rtl/bitpair_pkg.sv
`timescale 1ns/1ps
package bitpair_pkg;
  // Calibration controller states
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SEARCH = 2'd1,
    CAL_LOCK   = 2'd2
  } cal_state_t;

  // Test sequence rule: b[n] = b[n-PRBS_TAP] ^ b[n-PRBS_LEN]
  localparam int unsigned PRBS_LEN = 9;
  localparam int unsigned PRBS_TAP = 5;
endpackage

// File: rtl/bitpair_split.sv
`timescale 1ns/1ps
module bitpair_split (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic tx_bit_i,
  output logic ch_a_o,
  output logic ch_b_o
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ch_a_o <= 1'b0;
      ch_b_o <= 1'b0;
    end else if (stb_i) begin
      ch_a_o <= hold_q;
      ch_b_o <= tx_bit_i;
    end else begin
      hold_q <= tx_bit_i;
    end
  end

  // Channel outputs move only at the channel-rate boundary
  p_outputs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> ($stable(ch_a_o) && $stable(ch_b_o)));
endmodule

// File: rtl/bitpair_deskew.sv
`timescale 1ns/1ps
module bitpair_deskew #(
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             sel_a_cfg_i,
  input  logic             rx_a_i,
  input  logic             rx_b_i,
  output logic             out_bit_o
);
  localparam int unsigned DEPTH = 1 << DLY_W;

  logic             sel_a_q;
  logic [DEPTH-1:0] line_q;
  logic             raw_sel;
  logic             tap;
  logic [1:0]       raw;
  logic [1:0]       aligned;
  logic [1:0]       pair_q;

  assign raw     = {rx_b_i, rx_a_i};
  assign raw_sel = sel_a_q ? rx_a_i : rx_b_i;
  assign tap     = (dly_i == '0) ? raw_sel : line_q[dly_i - 1'b1];

  // Lane 0 is channel A, lane 1 is channel B; only the selected lane takes the tap
  for (genvar c = 0; c < 2; c++) begin : g_lane
    localparam bit IS_A = (c == 0);
    assign aligned[c] = (sel_a_q == IS_A) ? tap : raw[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_a_q <= sel_a_cfg_i;
      line_q  <= '0;
      pair_q  <= '0;
    end else if (stb_i) begin
      line_q <= {line_q[DEPTH-2:0], raw_sel};
      pair_q <= aligned;
    end
  end

  // A first (strobe low), then B (strobe high)
  assign out_bit_o = stb_i ? pair_q[1] : pair_q[0];

  // With a zero delay both lanes carry the bits just sampled
  p_zero_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && dly_i == '0) |=> (pair_q == $past(raw)));
endmodule

// File: rtl/bitpair_autocal.sv
`timescale 1ns/1ps
module bitpair_autocal
  import bitpair_pkg::*;
#(
  parameter int unsigned DLY_W  = 5,
  parameter int unsigned SETTLE = 16,
  parameter int unsigned WIN    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic             auto_i,
  input  logic             bit_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             err_o
);
  localparam int unsigned SPAN  = SETTLE + WIN;
  localparam int unsigned CNT_W = $clog2(SPAN);

  cal_state_t          st_q;
  logic [PRBS_LEN-1:0] hist_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                bad_q;
  logic                err_q;
  logic [DLY_W-1:0]    dly_q;
  logic                miss;
  logic                last;
  logic                in_win;
  logic                bad_nxt;

  assign miss    = bit_i ^ hist_q[PRBS_TAP-1] ^ hist_q[PRBS_LEN-1];
  assign last    = (cnt_q == CNT_W'(SPAN - 1));
  assign in_win  = (cnt_q >= CNT_W'(SETTLE));
  assign bad_nxt = bad_q | (miss & ((st_q == CAL_LOCK) | in_win));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CAL_IDLE;
      hist_q <= '0;
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      err_q  <= 1'b0;
      dly_q  <= dly_cfg_i;
    end else begin
      hist_q <= {hist_q[PRBS_LEN-2:0], bit_i};
      if (!auto_i) begin
        st_q  <= CAL_IDLE;
        cnt_q <= '0;
        bad_q <= 1'b0;
        err_q <= 1'b0;
      end else begin
        case (st_q)
          CAL_IDLE: begin
            st_q  <= CAL_SEARCH;
            dly_q <= '0;
            cnt_q <= '0;
            bad_q <= 1'b0;
            err_q <= 1'b1;
          end
          CAL_SEARCH: begin
            if (last) begin
              cnt_q <= '0;
              bad_q <= 1'b0;
              if (!bad_nxt) begin
                st_q  <= CAL_LOCK;
                err_q <= 1'b0;
              end else begin
                dly_q <= dly_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
              bad_q <= bad_nxt;
            end
          end
          CAL_LOCK: begin
            if (last) begin
              cnt_q <= '0;
              bad_q <= 1'b0;
              err_q <= bad_nxt;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              bad_q <= bad_nxt;
            end
          end
          default: st_q <= CAL_IDLE;
        endcase
      end
    end
  end

  assign dly_o = dly_q;
  assign err_o = err_q;

  p_search_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == CAL_SEARCH) |-> (dly_q == '0));
  p_search_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_SEARCH) |-> err_q);
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_LOCK) |=> $stable(dly_q));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_IDLE) |-> !err_q);
  p_idle_keeps_dly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_IDLE && !auto_i) |=> $stable(dly_q));
endmodule

// File: rtl/bitpair_mux.sv
`timescale 1ns/1ps
module bitpair_mux
  import bitpair_pkg::*;
#(
  parameter int unsigned DLY_W       = 5,
  parameter int unsigned SETTLE_BITS = 16,
  parameter int unsigned WIN_BITS    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit_i,
  output logic             stb64_o,
  output logic             ch_a_o,
  output logic             ch_b_o,
  input  logic             rx_a_i,
  input  logic             rx_b_i,
  output logic             out_bit_o,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic             dly_sel_a_i,
  input  logic             auto_i,
  output logic [DLY_W-1:0] cur_dly_o,
  output logic             err_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign stb64_o = phase_q;

  bitpair_split u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (phase_q),
    .tx_bit_i (tx_bit_i),
    .ch_a_o   (ch_a_o),
    .ch_b_o   (ch_b_o)
  );

  bitpair_deskew #(.DLY_W(DLY_W)) u_deskew (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_i       (phase_q),
    .dly_i       (cur_dly_o),
    .sel_a_cfg_i (dly_sel_a_i),
    .rx_a_i      (rx_a_i),
    .rx_b_i      (rx_b_i),
    .out_bit_o   (out_bit_o)
  );

  bitpair_autocal #(.DLY_W(DLY_W), .SETTLE(SETTLE_BITS), .WIN(WIN_BITS)) u_autocal (
    .clk       (clk),
    .rst_n     (rst_n),
    .dly_cfg_i (dly_cfg_i),
    .auto_i    (auto_i),
    .bit_i     (out_bit_o),
    .dly_o     (cur_dly_o),
    .err_o     (err_o)
  );

  p_strobe_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb64_o |=> stb64_o);
  p_strobe_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb64_o |=> !stb64_o);
endmodule

// File: tb/bitpair_mux_tb.sv
`timescale 1ns/1ps
module bitpair_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit_i = 1'b0;
  logic       rx_a_i = 1'b0;
  logic       rx_b_i = 1'b0;
  logic [4:0] dly_cfg_i = '0;
  logic       dly_sel_a_i = 1'b0;
  logic       auto_i = 1'b0;
  logic       stb64_o, ch_a_o, ch_b_o, out_bit_o, err_o;
  logic [4:0] cur_dly_o;

  int checks = 0;
  int errors = 0;
  bit pr [511];
  bit rn [512];
  int kk = 0;
  int skew_g = 0;
  bit late_b = 1'b0;
  bit use_prbs = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bitpair_mux dut_i (
    .clk(clk), .rst_n(rst_n), .tx_bit_i(tx_bit_i), .stb64_o(stb64_o),
    .ch_a_o(ch_a_o), .ch_b_o(ch_b_o), .rx_a_i(rx_a_i), .rx_b_i(rx_b_i),
    .out_bit_o(out_bit_o), .dly_cfg_i(dly_cfg_i), .dly_sel_a_i(dly_sel_a_i),
    .auto_i(auto_i), .cur_dly_o(cur_dly_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit xs(input int n);
    if (n < 0) return 1'b0;
    return use_prbs ? pr[n % 511] : rn[n % 512];
  endfunction

  task automatic do_reset(input int d, input bit sel_a);
    @(negedge clk);
    rst_n = 1'b0; auto_i = 1'b0;
    dly_cfg_i = 5'(d); dly_sel_a_i = sel_a;
    tx_bit_i = 1'b0; rx_a_i = 1'b0; rx_b_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    kk = 0;
  endtask

  // mode 0: no check, 1: exact stream, 2: test-sequence rule
  task automatic run_rx(input int npairs, input int mode, input int skip, input string tag);
    logic [8:0] oh = '0;
    for (int i = 0; i < npairs; i++) begin
      bit oa, ob, ea, eb;
      int j;
      @(negedge clk);
      if (stb64_o) @(negedge clk);
      if (late_b) begin
        rx_a_i = xs(2 * kk);
        rx_b_i = xs(2 * (kk - skew_g) + 1);
      end else begin
        rx_b_i = xs(2 * kk + 1);
        rx_a_i = xs(2 * (kk - skew_g));
      end
      oa = out_bit_o;
      @(negedge clk);
      ob = out_bit_o;
      j = kk - 1;
      if (i >= skip && mode == 1 && j - skew_g >= 0) begin
        ea = xs(2 * (j - skew_g));
        eb = xs(2 * (j - skew_g) + 1);
        chk(oa == ea, {tag, " A slot"}, oa, ea);
        chk(ob == eb, {tag, " B slot"}, ob, eb);
      end
      if (i >= skip && mode == 2) chk(oa == (oh[4] ^ oh[8]), {tag, " rule A"}, oa, oh[4] ^ oh[8]);
      oh = {oh[7:0], oa};
      if (i >= skip && mode == 2) chk(ob == (oh[4] ^ oh[8]), {tag, " rule B"}, ob, oh[4] ^ oh[8]);
      oh = {oh[7:0], ob};
      kk++;
    end
  endtask

  task automatic t_reset_state();
    do_reset(13, 1'b1);
    chk(ch_a_o == 1'b0, "R9 ch_a_o", ch_a_o, 0);
    chk(ch_b_o == 1'b0, "R9 ch_b_o", ch_b_o, 0);
    chk(out_bit_o == 1'b0, "R9 out_bit_o", out_bit_o, 0);
    chk(err_o == 1'b0, "R9 err_o", err_o, 0);
    chk(cur_dly_o == 5'd13, "R9 cur_dly_o", cur_dly_o, 13);
  endtask

  task automatic t_split();
    bit pa = 1'b0, pb = 1'b0;
    do_reset(0, 1'b0);
    for (int k = 0; k < 40; k++) begin
      bit sa, sb;
      @(negedge clk);
      if (stb64_o) @(negedge clk);
      if (k > 0) begin
        chk(ch_a_o == pa, "R1 channel A bit", ch_a_o, pa);
        chk(ch_b_o == pb, "R1 channel B bit", ch_b_o, pb);
      end
      sa = ch_a_o; sb = ch_b_o;
      pa = rn[(2 * k) % 512];
      pb = rn[(2 * k + 1) % 512];
      tx_bit_i = pa;
      @(negedge clk);
      chk(stb64_o == 1'b1, "R1 strobe alternates", stb64_o, 1);
      chk(ch_a_o == sa && ch_b_o == sb, "R1 hold between strobes", {ch_a_o, ch_b_o}, {sa, sb});
      tx_bit_i = pb;
    end
  endtask

  task automatic t_manual(input int d, input bit sel_a, input string tag);
    do_reset(d, sel_a);
    use_prbs = 1'b0; late_b = sel_a; skew_g = d;
    run_rx(d + 40, 1, d + 2, tag);
  endtask

  task automatic t_cfg_frozen();
    do_reset(3, 1'b1);
    use_prbs = 1'b0; late_b = 1'b1; skew_g = 3;
    run_rx(20, 1, 5, "R5 before change");
    dly_cfg_i = 5'd20; dly_sel_a_i = 1'b0;
    run_rx(40, 1, 0, "R5 pins changed without reset");
    chk(cur_dly_o == 5'd3, "R5 delay unchanged", cur_dly_o, 3);
    do_reset(20, 1'b0);
    chk(cur_dly_o == 5'd20, "R5 new delay after reset", cur_dly_o, 20);
    late_b = 1'b0; skew_g = 20;
    run_rx(60, 1, 22, "R5 applied after reset");
  endtask

  task automatic t_auto(input int s, input bit sel_a, input bit do_slip);
    int n = 0;
    do_reset(9, sel_a);
    use_prbs = 1'b1; late_b = sel_a; skew_g = s;
    run_rx(4, 0, 0, "");
    auto_i = 1'b1;
    run_rx(2, 0, 0, "");
    chk(err_o == 1'b1, "R6 err high while searching", err_o, 1);
    while (err_o && n < 3000) begin
      run_rx(1, 0, 0, "");
      n++;
    end
    chk(err_o == 1'b0, "R6 lock reached", err_o, 0);
    chk(cur_dly_o == 5'(s), "R6 first clean delay", cur_dly_o, s);
    run_rx(100, 2, 6, "R6 merged stream clean");
    if (do_slip) begin
      skew_g = s + 1;
      run_rx(150, 0, 0, "");
      chk(err_o == 1'b1, "R7 slip flagged", err_o, 1);
      chk(cur_dly_o == 5'(s), "R6 delay held after slip", cur_dly_o, s);
      skew_g = s;
      run_rx(150, 0, 0, "");
      chk(err_o == 1'b0, "R7 flag clears after clean window", err_o, 0);
      @(negedge clk);
      auto_i = 1'b0;
      run_rx(2, 0, 0, "");
      chk(err_o == 1'b0, "R8 err low with auto off", err_o, 0);
      chk(cur_dly_o == 5'(s), "R8 found delay kept", cur_dly_o, s);
      run_rx(60, 1, s + 2, "R8 data path keeps found delay");
    end
  endtask

  initial begin
    for (int i = 0; i < 9; i++) pr[i] = 1'b1;
    for (int i = 9; i < 511; i++) pr[i] = pr[i - 5] ^ pr[i - 9];
    for (int i = 0; i < 512; i++) rn[i] = 1'($urandom);

    t_reset_state();
    t_split();
    t_manual(0, 1'b1, "R2 R3 zero delay");
    t_manual(7, 1'b1, "R3 R4 delay on A");
    t_manual(7, 1'b0, "R4 delay on B");
    t_manual(31, 1'b0, "R3 maximum delay");
    t_cfg_frozen();
    t_auto(5, 1'b1, 1'b1);
    t_auto(12, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule